// File: doc/BRIEF.md
# 64-bit Interval Timer with Split-Word Register Access

The block is a memory-mapped interval timer. Its counter and its period are each two bus words wide. Software reaches it through a simple 32-bit register port. The count advances on ticks taken from one of two sources. The first is the bus clock itself. The second is a slower generic clock that runs asynchronously and is sampled into the bus domain. Either source is divided by a prescaler of 1 to 16 before it reaches the counter.

When the counter matches the programmed period, a pending flag is set. In continuous mode the counter then restarts from zero. In one-shot mode the counter freezes and the timer stops. The interrupt line is the pending flag gated by its enable bit. Reading the status word returns the flag and clears it. The 64-bit count is read as two words. A read of the low word captures the high word, so the two reads form one coherent value however far apart they are.

A typical driver sequence is: soft reset, write the mode, write the period high word, write the period low word, write the interrupt enable, then start. The bus word width is a parameter, and the counter is always twice that width.

Top module: `pit_timer64`

## Requirements
- R1: After reset, every readable register returns 0 and `irq` is 0.
- R2: A write to offset 0x00 with bit 8 set is a soft reset. It stops the timer, clears the count and clears the pending flag, and it wins over bit 0 in the same write. A write with only bit 0 set starts the timer. A read of 0x00 returns the running state in bit 0.
- R3: The mode word at 0x04 holds these fields: continuous mode in bit 0 (0 selects one-shot), generic-clock select in bit 3, and prescaler P in bits 11:8. It reads back with every other bit returning 0.
- R4: With the bus clock selected, tick k arrives on bus edge k·(P+1) after the start write. The period-match event therefore falls (period+1)·(P+1) bus edges after the start write.
- R5: A write to 0x0C only stages the high period word. A write to 0x08 loads {staged high, written low} as the active period. Offsets 0x08 and 0x0C read back the active period.
- R6: In one-shot mode the match event sets the pending flag and clears the running state. The count holds at the period value.
- R7: In continuous mode the match event resets the count to 0 and the timer keeps running, so an event occurs every (period+1)·(P+1) ticks of the source.
- R8: `irq` is high exactly when the pending flag is set and bit 0 of the enable word at 0x10 is set.
- R9: A read of 0x1C returns the pending flag in bit 0 and clears it. A match event in the same cycle keeps the flag set.
- R10: A read of 0x20 returns the live low count word and captures the high count word. A read of 0x24 returns the captured word.
- R11: With the generic clock selected, each rising edge of `gen_clk`, after a two-stage synchronizer, counts as one source tick for the prescaler.
- R12: A read of any offset not listed above returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| gen_clk | input | 1 | Asynchronous generic tick clock, at most one third of the `clk` rate |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the access cycle, 0 when no read is made |
| irq | output | 1 | Period-reached interrupt |

## Verification
The assertions check on every cycle how the timer moves from state to state. Each tick that does not match steps the count by exactly one. A one-shot match stops the timer, and a continuous match zeroes the count. A match raises the pending flag, and a status read without a match drops it. A soft reset clears the running state, the count and the flag. The interrupt never rises without its enable bit. Only the bench's scenarios can show the arithmetic timing: match after (period+1)·(P+1) edges across a sweep of prescalers and periods, the delay through the generic-clock synchronizer, the staging of the period words, and the coherence of the high-word capture across a real carry out of the low word.

// File: rtl/pit64_pkg.sv
package pit64_pkg;

    localparam int ADDR_W = 8;
    localparam int PRES_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_PER_LO = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_PER_HI = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_IEN    = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h24;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_KILL_BIT = 8;
    localparam int MODE_CONT_BIT = 0;
    localparam int MODE_GEN_BIT  = 3;
    localparam int MODE_PRES_LSB = 8;

    typedef struct packed {
        logic              cont;
        logic              gen_sel;
        logic [PRES_W-1:0] pres;
    } mode_t;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_MODE,
        SEL_PER_LO,
        SEL_PER_HI,
        SEL_IEN,
        SEL_STAT,
        SEL_CNT_LO,
        SEL_CNT_HI
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CTRL:   s = SEL_CTRL;
            OFS_MODE:   s = SEL_MODE;
            OFS_PER_LO: s = SEL_PER_LO;
            OFS_PER_HI: s = SEL_PER_HI;
            OFS_IEN:    s = SEL_IEN;
            OFS_STAT:   s = SEL_STAT;
            OFS_CNT_LO: s = SEL_CNT_LO;
            OFS_CNT_HI: s = SEL_CNT_HI;
            default:    s = SEL_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pit64_tick_gen.sv
module pit64_tick_gen
    import pit64_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_clk,
    input  logic              gen_sel,
    input  logic [PRES_W-1:0] pres,
    input  logic              run,
    output logic              tick
);
    // synchronizer stages plus one delayed copy for edge detection
    logic [SYNC_STAGES:0] sync_q;
    logic                 gen_rise;
    logic                 src_tick;
    logic [PRES_W-1:0]    div_q;
    logic                 div_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-1:0], gen_clk};
        end
    end

    assign gen_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
    assign src_tick = gen_sel ? gen_rise : 1'b1;
    assign div_hit  = (div_q >= pres);
    assign tick     = run & src_tick & div_hit;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (src_tick) begin
            if (div_hit) begin
                div_q <= '0;
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pit64_counter.sv
module pit64_counter #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             kill,
    input  logic             go,
    input  logic             cont,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             run,
    output logic             evt
);
    logic match;

    assign match = (count == period);
    assign evt   = tick & match;

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            count <= '0;
            run   <= 1'b0;
        end else begin
            if (go) begin
                run <= 1'b1;
            end
            if (tick) begin
                if (match) begin
                    if (cont) begin
                        count <= '0;
                    end else begin
                        run <= 1'b0;
                    end
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pit64_regs.sv
module pit64_regs
    import pit64_pkg::*;
#(
    parameter int BUS_W = 32,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              run,
    input  logic              evt,
    output mode_t             mode,
    output logic [CNT_W-1:0]  period,
    output logic              ien,
    output logic              pending,
    output logic              go,
    output logic              kill
);
    reg_sel_e         sel;
    logic             wr_en;
    logic             rd_en;
    logic [BUS_W-1:0] per_hi_stage;
    logic [BUS_W-1:0] cnt_hi_snap;

    assign sel   = decode_addr(bus_addr);
    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    assign kill = wr_en && (sel == SEL_CTRL) && bus_wdata[CTRL_KILL_BIT];
    assign go   = wr_en && (sel == SEL_CTRL) && bus_wdata[CTRL_GO_BIT]
                  && !bus_wdata[CTRL_KILL_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            mode         <= '0;
            period       <= '0;
            per_hi_stage <= '0;
            ien          <= 1'b0;
        end else if (wr_en) begin
            case (sel)
                SEL_MODE: begin
                    mode.cont    <= bus_wdata[MODE_CONT_BIT];
                    mode.gen_sel <= bus_wdata[MODE_GEN_BIT];
                    mode.pres    <= bus_wdata[MODE_PRES_LSB +: PRES_W];
                end
                SEL_PER_HI: per_hi_stage <= bus_wdata;
                SEL_PER_LO: period       <= {per_hi_stage, bus_wdata};
                SEL_IEN:    ien          <= bus_wdata[0];
                default: ;
            endcase
        end
    end

    // pending flag: set by a match, cleared by a status read or soft reset
    always_ff @(posedge clk) begin
        if (rst || kill) begin
            pending <= 1'b0;
        end else if (evt) begin
            pending <= 1'b1;
        end else if (rd_en && (sel == SEL_STAT)) begin
            pending <= 1'b0;
        end
    end

    // high word captured on each low-word read
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_hi_snap <= '0;
        end else if (rd_en && (sel == SEL_CNT_LO)) begin
            cnt_hi_snap <= count[CNT_W-1:BUS_W];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (sel)
                SEL_CTRL:   bus_rdata[CTRL_GO_BIT] = run;
                SEL_MODE: begin
                    bus_rdata[MODE_CONT_BIT]            = mode.cont;
                    bus_rdata[MODE_GEN_BIT]             = mode.gen_sel;
                    bus_rdata[MODE_PRES_LSB +: PRES_W]  = mode.pres;
                end
                SEL_PER_LO: bus_rdata    = period[BUS_W-1:0];
                SEL_PER_HI: bus_rdata    = period[CNT_W-1:BUS_W];
                SEL_IEN:    bus_rdata[0] = ien;
                SEL_STAT:   bus_rdata[0] = pending;
                SEL_CNT_LO: bus_rdata    = count[BUS_W-1:0];
                SEL_CNT_HI: bus_rdata    = cnt_hi_snap;
                default:    bus_rdata    = '0;
            endcase
        end
    end

endmodule

// File: rtl/pit_timer64.sv
module pit_timer64
    import pit64_pkg::*;
#(
    parameter int BUS_W = 32,
    localparam int CNT_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              gen_clk,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              irq
);
    mode_t            mode_w;
    logic [CNT_W-1:0] period_w;
    logic [CNT_W-1:0] count_w;
    logic             ien_w;
    logic             pending_w;
    logic             go_w;
    logic             kill_w;
    logic             tick_w;
    logic             evt_w;
    logic             run_w;

    pit64_regs #(.BUS_W(BUS_W)) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .count     (count_w),
        .run       (run_w),
        .evt       (evt_w),
        .mode      (mode_w),
        .period    (period_w),
        .ien       (ien_w),
        .pending   (pending_w),
        .go        (go_w),
        .kill      (kill_w)
    );

    pit64_tick_gen #(.SYNC_STAGES(2)) tick_i (
        .clk     (clk),
        .rst     (rst),
        .gen_clk (gen_clk),
        .gen_sel (mode_w.gen_sel),
        .pres    (mode_w.pres),
        .run     (run_w),
        .tick    (tick_w)
    );

    pit64_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_w),
        .kill   (kill_w),
        .go     (go_w),
        .cont   (mode_w.cont),
        .period (period_w),
        .count  (count_w),
        .run    (run_w),
        .evt    (evt_w)
    );

    assign irq = pending_w & ien_w;

endmodule

// File: rtl/pit64_checker.sv
module pit64_checker
    import pit64_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              tick,
    input logic              evt,
    input logic              run,
    input logic              cont,
    input logic [CNT_W-1:0]  count,
    input logic [CNT_W-1:0]  period,
    input logic              pending,
    input logic              kill,
    input logic              ien,
    input logic              irq
);
    logic             stat_rd;
    logic [CNT_W-1:0] count_nxt;

    assign stat_rd   = bus_sel && !bus_wr && (bus_addr == OFS_STAT);
    assign count_nxt = count + 1'b1;

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && (count != period) && !kill) |=> (count == $past(count_nxt))); // R4

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (rst)
        (evt && !cont) |=> !run); // R6

    AST_CONT_WRAP: assert property (@(posedge clk) disable iff (rst)
        (evt && cont && !kill) |=> (count == '0) && run); // R7

    AST_EVENT_FLAG: assert property (@(posedge clk) disable iff (rst)
        (evt && !kill) |=> pending); // R9

    AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !evt) |=> !pending); // R9

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
        irq |-> ien); // R8

    AST_KILL_CLEARS: assert property (@(posedge clk) disable iff (rst)
        kill |=> (!run && (count == '0) && !pending)); // R2

endmodule

bind pit_timer64 pit64_checker #(.CNT_W(CNT_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .tick     (tick_w),
    .evt      (evt_w),
    .run      (run_w),
    .cont     (mode_w.cont),
    .count    (count_w),
    .period   (period_w),
    .pending  (pending_w),
    .kill     (kill_w),
    .ien      (ien_w),
    .irq      (irq)
);

// File: tb/pit_timer64_tb.sv
module pit_timer64_tb_top;

    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          gen_clk = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [BW-1:0] bus_wdata = '0;
    logic [BW-1:0] bus_rdata;
    logic          irq;

    int nchk = 0;
    int nfail = 0;

    always #4 clk = ~clk;
    initial begin
        #3;
        forever #40 gen_clk = ~gen_clk;
    end

    pit_timer64 #(.BUS_W(BW)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .gen_clk   (gen_clk),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [BW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [BW-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        @(posedge clk);
        #1;
        bus_sel = 1'b0;
    endtask

    task automatic prog(input logic [31:0] per, input logic [BW-1:0] mode, input logic [BW-1:0] en);
        wr(8'h00, 16'h0100);
        wr(8'h04, mode);
        wr(8'h0C, per[31:16]);
        wr(8'h08, per[15:0]);
        wr(8'h10, en);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (1) begin
            @(posedge clk);
            n++;
            #1;
            if (irq || n >= 4000) break;
        end
    endtask

    initial begin
        #(8 * 190000);
        nfail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [BW-1:0] d;
        logic [BW-1:0] lo;
        int n;

        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1: reset state
        chk("R1 irq", {31'd0, irq}, 32'd0);
        rd(8'h00, d); chk("R1 ctrl", {16'd0, d}, 32'd0);
        rd(8'h04, d); chk("R1 mode", {16'd0, d}, 32'd0);
        rd(8'h08, d); chk("R1 period", {16'd0, d}, 32'd0);
        rd(8'h10, d); chk("R1 ien", {16'd0, d}, 32'd0);
        rd(8'h1C, d); chk("R1 status", {16'd0, d}, 32'd0);
        rd(8'h20, d); chk("R1 count", {16'd0, d}, 32'd0);

        // R3: mode field readback
        wr(8'h04, 16'h0F09); rd(8'h04, d); chk("R3 mode fields", {16'd0, d}, 32'h0F09);
        wr(8'h04, 16'hFFFF); rd(8'h04, d); chk("R3 undefined bits", {16'd0, d}, 32'h0F09);

        // R4/R6: one-shot sweep over prescaler and period, bus clock
        for (int pr = 0; pr < 4; pr++) begin
            for (int per = 0; per < 5; per++) begin
                prog(per, 16'(pr << 8), 16'h0001);
                wr(8'h00, 16'h0001);
                wait_irq(n);
                chk($sformatf("R4 match edge p=%0d per=%0d", pr, per), n, (per + 1) * (pr + 1));
                rd(8'h00, d); chk("R6 stopped", {16'd0, d}, 32'd0);
                rd(8'h20, d); chk("R6 count holds", {16'd0, d}, per);
                rd(8'h1C, d); chk("R9 status set", {16'd0, d}, 32'd1);
                chk("R9 irq cleared", {31'd0, irq}, 32'd0);
                rd(8'h1C, d); chk("R9 status cleared", {16'd0, d}, 32'd0);
            end
        end

        // R7: continuous, period 2, prescaler 1 -> 6 edges per event
        prog(32'd2, 16'h0101, 16'h0001);
        wr(8'h00, 16'h0001);
        wait_irq(n); chk("R7 first event", n, 32'd6);
        for (int i = 0; i < 3; i++) begin
            rd(8'h1C, d); chk("R7 flag", {16'd0, d}, 32'd1);
            wait_irq(n); chk("R7 repeat interval", n, 32'd5);
        end
        rd(8'h00, d); chk("R7 still running", {16'd0, d}, 32'd1);

        // R12: unmapped offsets while running
        rd(8'h14, d); chk("R12 0x14", {16'd0, d}, 32'd0);
        rd(8'h18, d); chk("R12 0x18", {16'd0, d}, 32'd0);
        rd(8'h30, d); chk("R12 0x30", {16'd0, d}, 32'd0);
        rd(8'hFC, d); chk("R12 0xFC", {16'd0, d}, 32'd0);

        // R9: match in the same cycle as the status read keeps the flag
        prog(32'd0, 16'h0001, 16'h0001);
        wr(8'h00, 16'h0001);
        repeat (3) @(posedge clk);
        rd(8'h1C, d); chk("R9 set", {16'd0, d}, 32'd1);
        rd(8'h1C, d); chk("R9 set wins", {16'd0, d}, 32'd1);

        // R2: soft reset clears run, count, pending; wins over start
        rd(8'h00, d); chk("R2 running", {16'd0, d}, 32'd1);
        wr(8'h00, 16'h0101);
        rd(8'h00, d); chk("R2 reset wins", {16'd0, d}, 32'd0);
        rd(8'h20, d); chk("R2 count cleared", {16'd0, d}, 32'd0);
        rd(8'h1C, d); chk("R2 pending cleared", {16'd0, d}, 32'd0);
        prog(32'd100, 16'h0001, 16'h0000);
        wr(8'h00, 16'h0001);
        repeat (5) @(posedge clk);
        rd(8'h20, d); chk("R2 restart count", {16'd0, d}, 32'd5);

        // R8: masked event, then enable
        prog(32'd3, 16'h0000, 16'h0000);
        wr(8'h00, 16'h0001);
        repeat (20) @(posedge clk);
        #1 chk("R8 masked", {31'd0, irq}, 32'd0);
        wr(8'h10, 16'h0001);
        chk("R8 enabled", {31'd0, irq}, 32'd1);
        wr(8'h10, 16'h0000);
        chk("R8 disabled again", {31'd0, irq}, 32'd0);
        rd(8'h1C, d); chk("R8 flag kept while masked", {16'd0, d}, 32'd1);

        // R5: high word staged until low word write
        prog(32'd5, 16'h0000, 16'h0001);
        wr(8'h0C, 16'h0001);
        rd(8'h0C, d); chk("R5 high staged", {16'd0, d}, 32'd0);
        rd(8'h08, d); chk("R5 low active", {16'd0, d}, 32'd5);
        wr(8'h00, 16'h0001);
        wait_irq(n); chk("R5 old period used", n, 32'd6);
        rd(8'h1C, d);
        wr(8'h00, 16'h0100);
        wr(8'h08, 16'h0002);
        rd(8'h0C, d); chk("R5 commit high", {16'd0, d}, 32'd1);
        rd(8'h08, d); chk("R5 commit low", {16'd0, d}, 32'd2);

        // R11: generic clock source, prescaler 1, period 3 -> 8 gen edges
        prog(32'd3, 16'h0108, 16'h0001);
        @(posedge gen_clk);
        repeat (5) @(posedge clk);
        wr(8'h00, 16'h0001);
        repeat (7) @(posedge gen_clk);
        repeat (5) @(posedge clk);
        #1 chk("R11 before 8th edge", {31'd0, irq}, 32'd0);
        @(posedge gen_clk);
        repeat (5) @(posedge clk);
        #1 chk("R11 at 8th edge", {31'd0, irq}, 32'd1);
        rd(8'h1C, d);

        // R10: coherent read across a low-word carry
        prog(32'hFFFF_FFFF, 16'h0001, 16'h0000);
        wr(8'h00, 16'h0001);
        repeat (65530) @(posedge clk);
        rd(8'h20, lo); chk("R10 low word", {16'd0, lo}, 32'h0000_FFFA);
        repeat (20) @(posedge clk);
        rd(8'h24, d); chk("R10 captured high", {16'd0, d}, 32'd0);
        rd(8'h20, lo);
        rd(8'h24, d); chk("R10 high after carry", {16'd0, d}, 32'd1);
        chk("R10 low after carry", {16'd0, lo} < 32'd64, 32'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule